// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent 32-bit timers that sit behind a small memory-mapped register bus. Each timer owns a control register and a count register, and drives its own interrupt request line. Once enabled, a timer decrements its live count by one on every clock. What happens when the count runs out depends on a two-bit mode field: the timer can stop after one expiry, reload and run again, or wrap around silently.

Software programs a timer in two steps. It first writes the count, which sets both the live value and the stored reload value. It then writes the control register with the enable bit and a mode. The live count can be read back at any time. A channel left in wrap mode with a full-scale count therefore works as a free-running 32-bit down-counting timebase. Each expiry that signals an event produces a single-cycle pulse on that channel's request line.

Top module: `tmr_bank8`

## Requirements
- R1: After reset every register reads zero, every channel is disabled and every interrupt line is low.
- R2: Channel c has its control register at byte address 8*c and its count register at 8*c+4. In the control register, bit 0 is the enable and bits [5:4] are the mode. All other control bits read as zero. A control write takes byte lane 0 and needs the low two address bits to be zero.
- R3: A count write loads the written byte lanes into both the live count and the reload value. Lanes whose byte enable is low keep the current live count bytes.
- R4: An enabled channel with a non-zero count decrements by exactly one per clock. A disabled channel holds its count.
- R5: In mode 1 or mode 3, an enabled channel whose count is zero raises its interrupt for one cycle, clears its enable bit and keeps its count at zero.
- R6: In mode 2, an enabled channel whose count is zero raises its interrupt for one cycle and reloads the stored reload value. The period is therefore reload+1 clocks.
- R7: In mode 0, an enabled channel whose count is zero wraps to 0xFFFFFFFF without an interrupt.
- R8: A control write first changes behaviour on the clock after the write edge. The write edge itself still counts (or does not count) under the old control value, so a disable freezes the count after that last step.
- R9: A count write on the same edge as an expiry wins. It suppresses that expiry's interrupt and its enable clearing, and loads the written value. A control write on an expiry edge does not suppress the expiry, but the written control value replaces the one the expiry would have left.
- R10: The channels are independent. Traffic to one channel never changes the count, control or interrupt of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 6 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 8 | Per-channel single-cycle interrupt pulses |

## Verification
The collision of interest is a software write landing on the same edge as a channel's expiry. The bench provokes it in two ways. It lets a one-shot channel count to zero and then writes its count on the very next edge. It also re-arms a zero-count channel's control register on the edge where it expires. In the first case it expects no pulse, the new count and a still-set enable. In the second it expects the pulse together with the freshly written mode, which then keeps the channel running. A per-clock behavioural model judges every interrupt line and the addressed register throughout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 32;
    localparam int LANES  = CNT_W / 8;

    localparam logic [1:0] MD_WRAP  = 2'd0;
    localparam logic [1:0] MD_ONCE  = 2'd1;
    localparam logic [1:0] MD_LOOP  = 2'd2;

    typedef struct packed {
        logic             en;
        logic [1:0]       mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             irq;
    } chan_st_t;
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 3
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_be,
    output logic [NCH-1:0] ctl_we,
    output logic [NCH-1:0] cnt_we
);
    logic aligned_wr;
    assign aligned_wr = bus_wr && (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        logic hit;
        assign hit       = aligned_wr && (bus_addr[AW-1:3] == CHW'(i));
        assign ctl_we[i] = hit && !bus_addr[2] && bus_be[0];
        assign cnt_we[i] = hit &&  bus_addr[2] && (|bus_be);
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic [1:0]       ctl_mode,
    input  logic             cnt_we,
    input  logic [LANES-1:0] cnt_be,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             en,
    output logic [1:0]       mode,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    chan_st_t st_d, st_q;
    logic [CNT_W-1:0] merged;

    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            merged[b*8 +: 8] = cnt_be[b] ? cnt_data[b*8 +: 8] : st_q.cnt[b*8 +: 8];
        end

        st_d     = st_q;
        st_d.irq = 1'b0;

        if (st_q.en) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                case (st_q.mode)
                    MD_WRAP: st_d.cnt = '1;
                    MD_LOOP: begin
                        st_d.cnt = st_q.rld;
                        st_d.irq = 1'b1;
                    end
                    default: begin
                        st_d.en  = 1'b0;
                        st_d.irq = 1'b1;
                    end
                endcase
            end
        end

        if (cnt_we) begin
            st_d.cnt = merged;
            st_d.rld = merged;
            st_d.en  = st_q.en;
            st_d.irq = 1'b0;
        end

        if (ctl_we) begin
            st_d.en   = ctl_en;
            st_d.mode = ctl_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign mode = st_q.mode;
    assign cnt  = st_q.cnt;
    assign irq  = st_q.irq;
endmodule

// File: rtl/tmr_bank8.sv
module tmr_bank8
    import tmr_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [LANES-1:0] bus_be,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [NCH-1:0]   irq
);
    logic [NCH-1:0]            ctl_we, cnt_we, ch_en;
    logic [NCH-1:0][1:0]       ch_mode;
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;

    tmr_dec #(.NCH(NCH)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .ctl_we  (ctl_we),
        .cnt_we  (cnt_we)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we[i]),
            .ctl_en  (bus_wdata[0]),
            .ctl_mode(bus_wdata[5:4]),
            .cnt_we  (cnt_we[i]),
            .cnt_be  (bus_be),
            .cnt_data(bus_wdata),
            .en      (ch_en[i]),
            .mode    (ch_mode[i]),
            .cnt     (ch_cnt[i]),
            .irq     (irq[i])
        );
    end

    logic [CHW-1:0] rsel;
    assign rsel = bus_addr[AW-1:3];

    always_comb begin
        if (bus_addr[2]) bus_rdata = ch_cnt[rsel];
        else             bus_rdata = {{(CNT_W-6){1'b0}}, ch_mode[rsel], 3'b000, ch_en[rsel]};
    end
endmodule

// File: rtl/tmr_bank8_chk.sv
module tmr_bank8_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0]            ch_en,
    input logic [NCH-1:0][1:0]       ch_mode,
    input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NCH-1:0]            ctl_we,
    input logic [NCH-1:0]            cnt_we
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R4
        dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_cnt[i] != '0 && !cnt_we[i]) |=> (ch_cnt[i] == $past(ch_cnt[i]) - 1'b1));
        // R4
        hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !cnt_we[i]) |=> $stable(ch_cnt[i]));
        // R5
        once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_cnt[i] == '0 && ch_mode[i][0] && !cnt_we[i] && !ctl_we[i])
            |=> (irq[i] && !ch_en[i] && ch_cnt[i] == '0));
        // R6
        loop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_cnt[i] == '0 && ch_mode[i] == MD_LOOP && !cnt_we[i]) |=> irq[i]);
        // R7
        wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && ch_cnt[i] == '0 && ch_mode[i] == MD_WRAP && !cnt_we[i])
            |=> (!irq[i] && ch_cnt[i] == '1));
        // R9
        load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_we[i] |=> !irq[i]);
        // R5
        pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(ch_en[i] && ch_cnt[i] == '0 && ch_mode[i] != MD_WRAP && !cnt_we[i]));
    end
endmodule

bind tmr_bank8 tmr_bank8_chk #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .ch_en  (ch_en),
    .ch_mode(ch_mode),
    .ch_cnt (ch_cnt),
    .ctl_we (ctl_we),
    .cnt_we (cnt_we)
);

// File: tb/tmr_bank8_tb.sv
module tmr_bank8_tb;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tmr_bank8 u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    bit          m_en   [8];
    bit [1:0]    m_mode [8];
    int unsigned m_cnt  [8];
    int unsigned m_rld  [8];
    bit          m_irq  [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin
                m_en[c] = 0; m_mode[c] = 0; m_cnt[c] = 0; m_rld[c] = 0; m_irq[c] = 0;
            end
        end else begin
            for (int c = 0; c < 8; c++) begin
                bit hit, cw, kw, n_en, n_irq;
                int unsigned n_cnt, n_rld, mg;
                hit = bus_wr && (bus_addr[5:3] == c) && (bus_addr[1:0] == 0);
                cw  = hit && !bus_addr[2] && bus_be[0];
                kw  = hit && bus_addr[2] && (bus_be != 0);
                n_en = m_en[c]; n_cnt = m_cnt[c]; n_rld = m_rld[c]; n_irq = 0;
                if (m_en[c]) begin
                    if (m_cnt[c] != 0) n_cnt = m_cnt[c] - 1;
                    else if (m_mode[c] == 0) n_cnt = 32'hFFFF_FFFF;
                    else if (m_mode[c] == 2) begin n_cnt = m_rld[c]; n_irq = 1; end
                    else begin n_en = 0; n_irq = 1; end
                end
                if (kw) begin
                    mg = m_cnt[c];
                    for (int b = 0; b < 4; b++)
                        if (bus_be[b]) mg[b*8 +: 8] = bus_wdata[b*8 +: 8];
                    n_cnt = mg; n_rld = mg; n_en = m_en[c]; n_irq = 0;
                end
                if (cw) begin
                    n_en = bus_wdata[0]; m_mode[c] = bus_wdata[5:4];
                end
                m_en[c] = n_en; m_cnt[c] = n_cnt; m_rld[c] = n_rld; m_irq[c] = n_irq;
            end
        end
    end

    // per-clock comparison against the model (R10 covers cross-channel leakage)
    always @(posedge clk) begin
        if (rst_n) begin
            logic [7:0]  e_irq;
            logic [31:0] e_rd;
            int          s;
            #(CLK_P/4);
            for (int c = 0; c < 8; c++) e_irq[c] = m_irq[c];
            s = bus_addr[5:3];
            e_rd = bus_addr[2] ? m_cnt[s] : {26'd0, m_mode[s], 3'd0, m_en[s]};
            chk("R10 model irq", {24'd0, irq}, {24'd0, e_irq});
            chk("R10 model rdata", bus_rdata, e_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 0; bus_be = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 64; a += 4) rd("R1 reset reg", 6'(a), 32'h0);
        chk("R1 reset irq", {24'd0, irq}, 32'h0);
        rst_n = 1;
        idle(1);

        // R2 / R3 map and byte lanes
        wr(6'd28, 32'h1234_5678, 4'hF);
        rd("R2 count at 8c+4", 6'd28, 32'h1234_5678);
        wr(6'd28, 32'h00AB_0000, 4'h4);
        rd("R3 lane merge", 6'd28, 32'h12AB_5678);
        wr(6'd24, 32'h0000_0030, 4'h1);
        rd("R2 ctrl at 8c", 6'd24, 32'h30);
        wr(6'd24, 32'hFFFF_FFFE, 4'h1);
        rd("R2 unused ctrl bits", 6'd24, 32'h30);
        wr(6'd24, 32'h0, 4'h1);

        // R8 / R4 enable timing, decrement, freeze
        wr(6'd4, 32'd10, 4'hF);
        wr(6'd0, 32'h11, 4'h1);
        rd("R8 no step on enable edge", 6'd4, 32'd10);
        idle(1);
        rd("R4 decrement", 6'd4, 32'd9);
        wr(6'd0, 32'h0, 4'h1);
        rd("R8 disable edge still steps", 6'd4, 32'd8);
        idle(5);
        rd("R4 frozen when disabled", 6'd4, 32'd8);

        // R5 one-shot
        wr(6'd12, 32'd3, 4'hF);
        wr(6'd8, 32'h11, 4'h1);
        idle(3);
        rd("R5 reached zero", 6'd12, 32'd0);
        chk("R5 no early irq", {31'd0, irq[1]}, 32'd0);
        idle(1);
        chk("R5 irq pulse", {31'd0, irq[1]}, 32'd1);
        rd("R5 enable cleared", 6'd8, 32'h10);
        idle(1);
        chk("R5 pulse one cycle", {31'd0, irq[1]}, 32'd0);
        rd("R5 held at zero", 6'd12, 32'd0);
        wr(6'd56, 32'h31, 4'h1);
        idle(1);
        chk("R5 mode3 irq", {31'd0, irq[7]}, 32'd1);
        rd("R5 mode3 enable cleared", 6'd56, 32'h30);

        // R6 periodic
        wr(6'd20, 32'd2, 4'hF);
        wr(6'd16, 32'h21, 4'h1);
        idle(3);
        chk("R6 first pulse", {31'd0, irq[2]}, 32'd1);
        rd("R6 reloaded", 6'd20, 32'd2);
        idle(1);
        chk("R6 pulse ends", {31'd0, irq[2]}, 32'd0);
        idle(2);
        chk("R6 second pulse", {31'd0, irq[2]}, 32'd1);
        wr(6'd16, 32'h0, 4'h1);

        // R7 wrap mode
        wr(6'd36, 32'd1, 4'hF);
        wr(6'd32, 32'h01, 4'h1);
        idle(2);
        rd("R7 wrapped", 6'd36, 32'hFFFF_FFFF);
        chk("R7 no irq", {31'd0, irq[4]}, 32'd0);
        idle(1);
        rd("R7 free-running", 6'd36, 32'hFFFF_FFFE);
        wr(6'd32, 32'h0, 4'h1);

        // R9 count write on expiry edge
        wr(6'd44, 32'd1, 4'hF);
        wr(6'd40, 32'h11, 4'h1);
        idle(1);
        wr(6'd44, 32'd7, 4'hF);
        chk("R9 load suppresses irq", {31'd0, irq[5]}, 32'd0);
        rd("R9 loaded value", 6'd44, 32'd7);
        rd("R9 still enabled", 6'd40, 32'h11);
        idle(1);
        rd("R9 counts on", 6'd44, 32'd6);
        wr(6'd40, 32'h0, 4'h1);

        // R9 control write on expiry edge
        wr(6'd52, 32'd0, 4'hF);
        wr(6'd48, 32'h11, 4'h1);
        wr(6'd48, 32'h21, 4'h1);
        chk("R9 expiry pulse kept", {31'd0, irq[6]}, 32'd1);
        rd("R9 written ctrl wins", 6'd48, 32'h21);
        idle(1);
        chk("R6 zero reload repeats", {31'd0, irq[6]}, 32'd1);
        wr(6'd48, 32'h0, 4'h1);

        // R10 independence
        rd("R10 channel 0 untouched", 6'd4, 32'd8);
        rd("R10 channel 3 untouched", 6'd28, 32'h12AB_5678);
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule